// File: doc/BRIEF.md
# Integer Execute Unit with Companion High Registers

This block executes one decoded integer operation per issue against a register file. The file has as many registers as the data path has bits (W registers of W bits). Each register has a companion high register at the same index. An issue carries an opcode, a destination index and a second operand. The second operand is either a register index or an immediate. The result goes back into the destination register, its companion, or one of three special registers: the remainder register, the shift-count register and the flags register.

The companion register extends the destination to a 2W-bit value for three operations:
- Multiply deposits the upper half of the full product in the companion.
- Left shift deposits the bits pushed off the top in the companion.
- Divide reads the companion as the upper half of its dividend.

Divide runs one quotient bit per cycle. While it runs, the unit raises `busy` and ignores new issues. A read port exposes any register pair, and output ports expose the special registers, so that results can be observed.

Top module: `xu_core`

## Requirements
- R1: After reset, every general and companion register, the remainder, the shift count and all flags read zero, and `busy` is low.
- R2: Opcodes ADD=0, SUB=1, AND=4, OR=5, XOR=6 write dst op operand, truncated to W bits, into the destination register and leave its companion unchanged. The operand is the immediate when `issue_use_imm`=1, otherwise the register at `issue_src`.
- R3: INC=2 and DEC=3 add or subtract one from the destination (modulo 2^W). NOT=7 replaces the destination with its bitwise complement. All three ignore the operand.
- R4: MUL=8 forms the unsigned 2W-bit product. The low half goes to the destination register and the high half goes to its companion.
- R5: DIV=9 divides the unsigned dividend {companion, destination} by the operand. The quotient goes to the destination, the companion is cleared, and the remainder goes to the remainder register (`rem_out`).
- R6: A DIV whose divisor is zero, or whose companion is greater than or equal to the divisor, sets error flag bit 4. It changes no register and does not raise `busy`.
- R7: An accepted DIV keeps `busy` high for exactly W+1 cycles. A successful DIV clears flag bit 4.
- R8: CMP=14 computes destination minus operand without writing any register. It sets flag bits 0 (zero), 1 (sign of the difference), 2 (unsigned borrow) and 3 (signed overflow).
- R9: SHL=10 by n shifts the destination left. The n bits shifted out go to the companion, right-aligned. A count of zero writes zero to the companion.
- R10: SHR=11 (logical), ROL=12 and ROR=13 rewrite only the destination register and leave its companion unchanged.
- R11: The shift count is the immediate when `issue_use_imm`=1, otherwise the shift-count register. Either way it is taken modulo W. SETSC=15 loads the shift-count register with the operand.
- R12: An issue presented while `busy` is high has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is presented |
| issue_op | input | 4 | Opcode |
| issue_dst | input | log2(W) | Destination register index |
| issue_use_imm | input | 1 | Operand is the immediate rather than a register |
| issue_src | input | log2(W) | Operand register index |
| issue_imm | input | W | Immediate operand |
| busy | output | 1 | Divide in progress; issues are ignored |
| rd_idx | input | log2(W) | Read-port register index |
| rd_lo | output | W | General register at `rd_idx` |
| rd_hi | output | W | Companion register at `rd_idx` |
| rem_out | output | W | Remainder register |
| sc_out | output | W | Shift-count register |
| flags_out | output | 5 | Flags: 0 zero, 1 sign, 2 borrow, 3 overflow, 4 divide error |

## Verification
The bench builds the unit with W=8, which gives eight register pairs. At this width an ordinary constant is enough to wrap an addition, carry a product into the companion, and make a quotient overflow. The same width puts shift counts above W within reach, so the modulo rule can be exercised. The W+1-cycle divide window can be counted exactly, and an issue can be injected into the middle of it.

// File: rtl/xu_pkg.sv
package xu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_INC   = 4'd2,
        OP_DEC   = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_NOT   = 4'd7,
        OP_MUL   = 4'd8,
        OP_DIV   = 4'd9,
        OP_SHL   = 4'd10,
        OP_SHR   = 4'd11,
        OP_ROL   = 4'd12,
        OP_ROR   = 4'd13,
        OP_CMP   = 4'd14,
        OP_SETSC = 4'd15
    } xu_op_e;

    localparam int FL_Z = 0;
    localparam int FL_S = 1;
    localparam int FL_C = 2;
    localparam int FL_V = 3;
    localparam int FL_E = 4;
    localparam int FLW  = 5;

endpackage

// File: rtl/xu_alu.sv
module xu_alu
    import xu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  xu_op_e          op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [SW-1:0]   shamt_i,
    output logic [W-1:0]    lo_o,
    output logic [W-1:0]    hi_o,
    output logic            wr_lo_o,
    output logic            wr_hi_o,
    output logic [3:0]      cmp_o,
    output logic            wr_cmp_o
);
    localparam int W2 = 2 * W;

    logic [W2-1:0] prod;
    logic [W2-1:0] shl_wide;
    logic [W2-1:0] rol_wide;
    logic [W2-1:0] ror_wide;
    logic [W:0]    diff;

    always_comb begin
        prod     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        shl_wide = {{W{1'b0}}, a_i} << shamt_i;
        rol_wide = {a_i, a_i} << shamt_i;
        ror_wide = {a_i, a_i} >> shamt_i;
        diff     = {1'b0, a_i} - {1'b0, b_i};

        lo_o     = '0;
        hi_o     = '0;
        wr_lo_o  = 1'b0;
        wr_hi_o  = 1'b0;
        wr_cmp_o = 1'b0;
        cmp_o    = '0;
        cmp_o[FL_Z] = (diff[W-1:0] == '0);
        cmp_o[FL_S] = diff[W-1];
        cmp_o[FL_C] = diff[W];
        cmp_o[FL_V] = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ diff[W-1]);

        unique case (op_i)
            OP_ADD: begin lo_o = a_i + b_i;      wr_lo_o = 1'b1; end
            OP_SUB: begin lo_o = diff[W-1:0];    wr_lo_o = 1'b1; end
            OP_INC: begin lo_o = a_i + 1'b1;     wr_lo_o = 1'b1; end
            OP_DEC: begin lo_o = a_i - 1'b1;     wr_lo_o = 1'b1; end
            OP_AND: begin lo_o = a_i & b_i;      wr_lo_o = 1'b1; end
            OP_OR:  begin lo_o = a_i | b_i;      wr_lo_o = 1'b1; end
            OP_XOR: begin lo_o = a_i ^ b_i;      wr_lo_o = 1'b1; end
            OP_NOT: begin lo_o = ~a_i;           wr_lo_o = 1'b1; end
            OP_MUL: begin
                lo_o = prod[W-1:0];
                hi_o = prod[W2-1:W];
                wr_lo_o = 1'b1;
                wr_hi_o = 1'b1;
            end
            OP_SHL: begin
                lo_o = shl_wide[W-1:0];
                hi_o = shl_wide[W2-1:W];
                wr_lo_o = 1'b1;
                wr_hi_o = 1'b1;
            end
            OP_SHR: begin lo_o = a_i >> shamt_i;       wr_lo_o = 1'b1; end
            OP_ROL: begin lo_o = rol_wide[W2-1:W];     wr_lo_o = 1'b1; end
            OP_ROR: begin lo_o = ror_wide[W-1:0];      wr_lo_o = 1'b1; end
            OP_CMP: begin wr_cmp_o = 1'b1; end
            default: begin end
        endcase
    end
endmodule

// File: rtl/xu_div.sv
module xu_div #(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  hi_i,
    input  logic [W-1:0]  lo_i,
    input  logic [W-1:0]  dvs_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  quo_o,
    output logic [W-1:0]  rem_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          fin;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic [W-1:0]  hi0;
        logic [W-1:0]  lo0;
    } dv_t;

    dv_t         dv_q, dv_d;
    logic [W:0]  trial;
    logic        qbit;

    always_comb begin
        dv_d     = dv_q;
        dv_d.fin = 1'b0;
        trial    = {dv_q.rem, dv_q.quo[W-1]};
        qbit     = (trial >= {1'b0, dv_q.dvs});
        if (qbit) begin
            trial = trial - {1'b0, dv_q.dvs};
        end
        if (dv_q.busy) begin
            dv_d.rem = trial[W-1:0];
            dv_d.quo = {dv_q.quo[W-2:0], qbit};
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.fin  = 1'b1;
            end
        end else if (start_i) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CW'(W);
            dv_d.rem  = hi_i;
            dv_d.quo  = lo_i;
            dv_d.dvs  = dvs_i;
            dv_d.hi0  = hi_i;
            dv_d.lo0  = lo_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign busy_o = dv_q.busy;
    assign done_o = dv_q.fin;
    assign quo_o  = dv_q.quo;
    assign rem_o  = dv_q.rem;

    assert_start_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !dv_q.busy && !dv_q.fin);

    assert_div_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.fin |-> (({{W{1'b0}}, dv_q.quo} * {{W{1'b0}}, dv_q.dvs}
                      + {{W{1'b0}}, dv_q.rem}) == {dv_q.hi0, dv_q.lo0}));

    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.fin |-> (dv_q.rem < dv_q.dvs));
endmodule

// File: rtl/xu_core.sv
module xu_core
    import xu_pkg::*;
#(
    parameter int W  = 32,
    localparam int IW = $clog2(W),
    localparam int SW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_valid,
    input  logic [3:0]     issue_op,
    input  logic [IW-1:0]  issue_dst,
    input  logic           issue_use_imm,
    input  logic [IW-1:0]  issue_src,
    input  logic [W-1:0]   issue_imm,
    output logic           busy,
    input  logic [IW-1:0]  rd_idx,
    output logic [W-1:0]   rd_lo,
    output logic [W-1:0]   rd_hi,
    output logic [W-1:0]   rem_out,
    output logic [W-1:0]   sc_out,
    output logic [4:0]     flags_out
);
    typedef struct packed {
        logic [FLW-1:0] flags;
        logic [W-1:0]   rem;
        logic [W-1:0]   sc;
        logic [IW-1:0]  ddst;
    } st_t;

    logic [W-1:0] gpr_q [W];
    logic [W-1:0] gpr_d [W];
    logic [W-1:0] hi_q  [W];
    logic [W-1:0] hi_d  [W];
    st_t          st_q, st_d;

    xu_op_e        op;
    logic          acc;
    logic [W-1:0]  a_val, ahi_val, b_val;
    logic [SW-1:0] shamt;
    logic          is_div, div_bad, div_start;

    logic [W-1:0]  alu_lo, alu_hi;
    logic          alu_wr_lo, alu_wr_hi, alu_wr_cmp;
    logic [3:0]    alu_cmp;
    logic          div_busy, div_done;
    logic [W-1:0]  div_quo, div_rem;

    assign op        = xu_op_e'(issue_op);
    assign busy      = div_busy | div_done;
    assign acc       = issue_valid && !busy;
    assign a_val     = gpr_q[issue_dst];
    assign ahi_val   = hi_q[issue_dst];
    assign b_val     = issue_use_imm ? issue_imm : gpr_q[issue_src];
    assign shamt     = issue_use_imm ? issue_imm[SW-1:0] : st_q.sc[SW-1:0];
    assign is_div    = acc && (op == OP_DIV);
    assign div_bad   = (b_val == '0) || (ahi_val >= b_val);
    assign div_start = is_div && !div_bad;

    xu_alu #(.W(W), .SW(SW)) u_alu (
        .op_i     (op),
        .a_i      (a_val),
        .b_i      (b_val),
        .shamt_i  (shamt),
        .lo_o     (alu_lo),
        .hi_o     (alu_hi),
        .wr_lo_o  (alu_wr_lo),
        .wr_hi_o  (alu_wr_hi),
        .cmp_o    (alu_cmp),
        .wr_cmp_o (alu_wr_cmp)
    );

    xu_div #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .hi_i    (ahi_val),
        .lo_i    (a_val),
        .dvs_i   (b_val),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (div_quo),
        .rem_o   (div_rem)
    );

    always_comb begin
        gpr_d = gpr_q;
        hi_d  = hi_q;
        st_d  = st_q;
        if (div_done) begin
            gpr_d[st_q.ddst]  = div_quo;
            hi_d[st_q.ddst]   = '0;
            st_d.rem          = div_rem;
            st_d.flags[FL_E]  = 1'b0;
        end
        if (acc) begin
            if (alu_wr_lo)  gpr_d[issue_dst] = alu_lo;
            if (alu_wr_hi)  hi_d[issue_dst]  = alu_hi;
            if (alu_wr_cmp) st_d.flags[3:0]  = alu_cmp;
            if (op == OP_SETSC) st_d.sc = b_val;
            if (is_div) begin
                if (div_bad) st_d.flags[FL_E] = 1'b1;
                else         st_d.ddst        = issue_dst;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < W; i++) begin
                gpr_q[i] <= '0;
                hi_q[i]  <= '0;
            end
            st_q <= '0;
        end else begin
            gpr_q <= gpr_d;
            hi_q  <= hi_d;
            st_q  <= st_d;
        end
    end

    assign rd_lo     = gpr_q[rd_idx];
    assign rd_hi     = hi_q[rd_idx];
    assign rem_out   = st_q.rem;
    assign sc_out    = st_q.sc;
    assign flags_out = st_q.flags;

    assert_sc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && op == OP_SETSC) |=> $stable(sc_out));

    assert_div_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_div && b_val == '0) |=> (flags_out[FL_E] && !busy));

    assert_cmp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == OP_CMP) |=> (flags_out[FL_Z] == ($past(a_val) == $past(b_val))));

    assert_rem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !div_done) |=> $stable(rem_out));

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |=> busy);
endmodule

// File: tb/xu_core_test.sv
module xu_core_test;
    localparam int W  = 8;
    localparam int IW = 3;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [3:0]    issue_op = '0;
    logic [IW-1:0] issue_dst = '0;
    logic          issue_use_imm = 1'b0;
    logic [IW-1:0] issue_src = '0;
    logic [W-1:0]  issue_imm = '0;
    logic          busy;
    logic [IW-1:0] rd_idx = '0;
    logic [W-1:0]  rd_lo, rd_hi, rem_out, sc_out;
    logic [4:0]    flags_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_lo [W];
    logic [W-1:0] m_hi [W];
    logic [W-1:0] m_rem, m_sc;
    logic [4:0]   m_fl;

    xu_core #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_use_imm(issue_use_imm), .issue_src(issue_src),
        .issue_imm(issue_imm), .busy(busy), .rd_idx(rd_idx), .rd_lo(rd_lo),
        .rd_hi(rd_hi), .rem_out(rem_out), .sc_out(sc_out), .flags_out(flags_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input int idx);
        rd_idx = IW'(idx);
        #1;
        chk(tag, $sformatf("r%0d lo", idx), int'(rd_lo), int'(m_lo[idx]));
        chk(tag, $sformatf("r%0d hi", idx), int'(rd_hi), int'(m_hi[idx]));
    endtask

    task automatic chk_all(input string tag, input int idx);
        chk_reg(tag, idx);
        chk(tag, "flags", int'(flags_out), int'(m_fl));
        chk(tag, "rem", int'(rem_out), int'(m_rem));
        chk(tag, "shift count", int'(sc_out), int'(m_sc));
    endtask

    // Behavioural model of one operation; returns 1 if a divide will run.
    function automatic bit model(input int op, input int dst, input bit ui,
                                 input int src, input int imm);
        int a, ah, b, n, full, q, r, sa, sb, sd;
        bit run;
        run = 1'b0;
        a  = int'(m_lo[dst]);
        ah = int'(m_hi[dst]);
        b  = ui ? imm : int'(m_lo[src]);
        n  = (ui ? imm : int'(m_sc)) % W;
        case (op)
            0:  m_lo[dst] = W'(a + b);
            1:  m_lo[dst] = W'(a - b);
            2:  m_lo[dst] = W'(a + 1);
            3:  m_lo[dst] = W'(a - 1);
            4:  m_lo[dst] = W'(a & b);
            5:  m_lo[dst] = W'(a | b);
            6:  m_lo[dst] = W'(a ^ b);
            7:  m_lo[dst] = W'(~a);
            8: begin
                full = a * b;
                m_lo[dst] = W'(full);
                m_hi[dst] = W'(full / (1 << W));
            end
            9: begin
                if (b == 0 || ah >= b) begin
                    m_fl[4] = 1'b1;
                end else begin
                    full = ah * (1 << W) + a;
                    q = full / b;
                    r = full % b;
                    m_lo[dst] = W'(q);
                    m_hi[dst] = '0;
                    m_rem = W'(r);
                    m_fl[4] = 1'b0;
                    run = 1'b1;
                end
            end
            10: begin
                full = a * (1 << n);
                m_lo[dst] = W'(full);
                m_hi[dst] = W'(full / (1 << W));
            end
            11: m_lo[dst] = W'(a / (1 << n));
            12: m_lo[dst] = W'((a * (1 << n)) + (a / (1 << (W - n))));
            13: m_lo[dst] = W'((a / (1 << n)) + (a * (1 << (W - n))));
            14: begin
                sa = (a >= (1 << (W - 1))) ? a - (1 << W) : a;
                sb = (b >= (1 << (W - 1))) ? b - (1 << W) : b;
                sd = sa - sb;
                m_fl[0] = (W'(a - b) == 0);
                m_fl[1] = ((a - b + (1 << W)) / (1 << (W - 1))) % 2 == 1;
                m_fl[2] = (a < b);
                m_fl[3] = (sd > (1 << (W - 1)) - 1) || (sd < -(1 << (W - 1)));
            end
            default: m_sc = W'(b);
        endcase
        return run;
    endfunction

    task automatic run_op(input int op, input int dst, input bit ui, input int src,
                          input int imm, input string tag, input bit poke = 1'b0);
        bit run;
        int bcnt;
        run = model(op, dst, ui, src, imm);
        @(negedge clk);
        issue_valid   = 1'b1;
        issue_op      = 4'(op);
        issue_dst     = IW'(dst);
        issue_use_imm = ui;
        issue_src     = IW'(src);
        issue_imm     = W'(imm);
        @(negedge clk);
        issue_valid = 1'b0;
        if (run) begin
            bcnt = 0;
            while (busy) begin
                if (poke && bcnt == 2) begin
                    issue_valid = 1'b1;
                    issue_op = 4'd0;
                    issue_dst = 3'd5;
                    issue_use_imm = 1'b1;
                    issue_imm = 8'd9;
                end else begin
                    issue_valid = 1'b0;
                end
                bcnt++;
                @(negedge clk);
            end
            issue_valid = 1'b0;
            chk("R7", "busy cycles", bcnt, W + 1);
        end else begin
            chk(tag, "busy", int'(busy), 0);
        end
        chk_all(tag, dst);
    endtask

    initial begin
        for (int i = 0; i < W; i++) begin
            m_lo[i] = '0;
            m_hi[i] = '0;
        end
        m_rem = '0; m_sc = '0; m_fl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < W; i++) chk_reg("R1", i);
        chk_all("R1", 0);
        chk("R1", "busy", int'(busy), 0);

        // R2 binary ops, immediate and register operands, wrap
        run_op(0, 1, 1, 0, 200, "R2");
        run_op(0, 1, 1, 0, 100, "R2");
        run_op(0, 2, 1, 0, 7,   "R2");
        run_op(1, 2, 0, 1, 0,   "R2");
        run_op(4, 2, 1, 0, 8'h3C, "R2");
        run_op(5, 2, 0, 1, 0,   "R2");
        run_op(6, 2, 1, 0, 8'hFF, "R2");

        // R3 inc, dec, not
        run_op(3, 3, 1, 0, 55, "R3");
        run_op(3, 3, 0, 1, 0,  "R3");
        run_op(2, 3, 0, 2, 0,  "R3");
        run_op(7, 3, 1, 0, 1,  "R3");

        // R4 multiply into companion
        run_op(0, 4, 1, 0, 200, "R4");
        run_op(8, 4, 1, 0, 3,   "R4");

        // R5 / R7 divide, with an ignored issue during busy (R12)
        run_op(9, 4, 1, 0, 7, "R5", 1'b1);
        chk_reg("R12", 5);

        // R6 divide errors, then a successful divide clears the error (R7)
        run_op(9, 4, 0, 0, 0, "R6");
        run_op(0, 6, 1, 0, 100, "R6");
        run_op(8, 6, 1, 0, 10,  "R6");
        run_op(9, 6, 1, 0, 3,   "R6");
        run_op(9, 6, 1, 0, 4,   "R7");

        // R8 compare
        run_op(14, 1, 1, 0, 44,  "R8");
        run_op(14, 1, 1, 0, 50,  "R8");
        run_op(0, 7, 1, 0, 8'h90, "R8");
        run_op(14, 7, 1, 0, 8'h70, "R8");
        run_op(14, 1, 0, 7, 0,  "R8");

        // R9 left shift into companion, zero count
        run_op(6, 7, 0, 7, 0,    "R9");
        run_op(0, 7, 1, 0, 8'hB5, "R9");
        run_op(10, 7, 1, 0, 3,   "R9");
        run_op(10, 7, 1, 0, 0,   "R9");

        // R10 / R11 right shift and rotates, counts from register and immediate
        run_op(15, 0, 1, 0, 11,  "R11");
        run_op(0, 5, 1, 0, 8'hC3, "R10");
        run_op(11, 5, 0, 0, 0,   "R11");
        run_op(12, 7, 1, 0, 2,   "R10");
        run_op(13, 7, 1, 0, 9,   "R11");
        run_op(13, 4, 0, 0, 0,   "R10");
        run_op(10, 1, 1, 0, 10,  "R11");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule